// File: doc/BRIEF.md
# Legacy NMI and Speaker Control Ports

This block holds the two legacy system-control byte ports of a PC-style chipset: the status/control port B and the write-only NMI-mask and RTC-index port. Software writes port B to gate interval-timer counter 2, to let that counter's output drive the speaker, and to enable or clear the two NMI error sources: the channel-check error and the PCI system error. A port B read returns the live counter 2 output, a bit that flips after every refresh cycle, the last written control bits and two sticky error flags. The bus decoding sits outside this block. It supplies one write strobe per port and a byte of write data. The port B read byte is driven continuously.

Each error source owns a small state machine with three states. ERR_ARMED means the source is enabled and clear. ERR_LATCHED means an error was captured and is sticky. ERR_DISABLED means software wrote 1 to the source's control bit. There are three transitions. CAPTURE runs from ERR_ARMED to ERR_LATCHED when the synchronised error input is active. CLEAR runs from any state to ERR_DISABLED when a port B write carries 1 in the source's bit, and CLEAR wins over CAPTURE in the same cycle. ENABLE runs from ERR_DISABLED to ERR_ARMED when a port B write carries 0 in that bit. A write of 0 leaves ERR_ARMED and ERR_LATCHED unchanged. Both error inputs are active low and pass through a two-flop synchroniser. The NMI request is raised when any source is in ERR_LATCHED and the master mask is 0.

The second port sets the master mask (bit 7, 1 = masked) and a 7-bit RTC index. The RTC index is passed straight to an external clock device and has no effect on NMI.

Top module: `legacy_sysctl_ports`

## Requirements
- R1: After reset, the port B read byte is 8'h00 when counter 2 output is low, tmr2_gate, spkr and nmi_req are 0, rtc_index is 0, and the master NMI mask is 1, so a captured error does not raise nmi_req until port 070 bit 7 is written 0.
- R2: A port B write sets tmr2_gate and read bit 0 to write-data bit 0 from the next cycle on.
- R3: spkr equals counter 2 output when port B bit 1 was last written 1, and is 0 when that bit was last written 0.
- R4: Read bit 4 flips once in the cycle after each cycle with refresh_pulse high. Port B writes never change read bit 4, whatever value write-data bit 4 carries.
- R5: When a source is enabled and its active-low input is held low, its flag is set three clock edges after the input first goes low. The flag stays set after the input returns high. The SERR flag is read bit 7 (source bit 2). The IOCHK flag is read bit 6 (source bit 3).
- R6: A port B write with 1 in a source's control bit clears that source's flag and blocks further captures. A write with 0 re-enables the source but does not clear a flag that is already set.
- R7: nmi_req is 1 exactly when read bit 7 or read bit 6 is set and the master mask is 0.
- R8: A write to port 070 loads the master mask from bit 7 and rtc_index from bits 6:0. rtc_index has no effect on nmi_req.
- R9: Read bit 5 shows the current counter 2 output. Read bits 3:0 return the last values written to port B bits 3:0.
- R10: If a port B write with 1 in a source's bit falls in the same cycle as that source's capture, the write wins: the flag is 0 and the read control bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| portb_wr | input | 1 | Port B write strobe, one cycle |
| rtcidx_wr | input | 1 | Port 070 write strobe, one cycle |
| wr_data | input | 8 | Write data byte |
| portb_rdata | output | 8 | Port B read byte |
| chk_err_n | input | 1 | Channel-check error, active low, asynchronous |
| bus_err_n | input | 1 | PCI system error, active low, asynchronous |
| refresh_pulse | input | 1 | High for one cycle per completed refresh |
| tmr2_out | input | 1 | Interval-timer counter 2 output |
| tmr2_gate | output | 1 | Counter 2 enable |
| spkr | output | 1 | Speaker output |
| nmi_req | output | 1 | NMI request |
| rtc_index | output | 7 | RTC address forwarded to the clock device |

## Verification
The bench drives each error input while the source is in each of its three states, and with the master mask both set and clear. This separates a flag that is captured from one that is sticky, one that is cleared and one that is merely masked. It places a clear-and-disable write in exactly the cycle of capture to show which transition has priority. It toggles counter 2 output under both speaker-gate settings, and it writes port B with bit 4 set between refresh pulses to show that the toggle bit follows only refresh. A long random phase of mixed writes, error pulses and refresh pulses is compared every cycle against a behavioural model.

// File: rtl/legacy_ports_pkg.sv
package legacy_ports_pkg;

    localparam int BYTE_W = 8;
    localparam int RTC_AW = BYTE_W - 1;
    localparam int NUM_ERR_SRC = 2;

    typedef enum logic [1:0] {
        ERR_ARMED    = 2'b00,
        ERR_LATCHED  = 2'b01,
        ERR_DISABLED = 2'b10
    } err_state_e;

endpackage

// File: rtl/lp_sync_chain.sv
module lp_sync_chain #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/lp_err_source.sv
module lp_err_source
    import legacy_ports_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic err_hit,
    input  logic wr_ctl,
    input  logic wr_bit,
    output logic flag,
    output logic dis
);

    err_state_e state_q;
    err_state_e state_d;
    logic       clear_req;

    assign clear_req = wr_ctl && wr_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ERR_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ERR_ARMED: begin
                if (clear_req) begin
                    state_d = ERR_DISABLED;
                end else if (err_hit) begin
                    state_d = ERR_LATCHED;
                end
            end
            ERR_LATCHED: begin
                if (clear_req) begin
                    state_d = ERR_DISABLED;
                end
            end
            ERR_DISABLED: begin
                if (wr_ctl && !wr_bit) begin
                    state_d = ERR_ARMED;
                end
            end
            default: state_d = ERR_ARMED;
        endcase
    end

    always_comb begin
        flag = (state_q == ERR_LATCHED);
        dis  = (state_q == ERR_DISABLED);
    end

    assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |=> (!flag && dis))
        else $error("clear-and-disable write did not win");

    assert_sticky_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clear_req) |=> flag)
        else $error("latched flag dropped without a clear write");

    assert_no_capture_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dis && !wr_ctl) |=> !flag)
        else $error("disabled source captured an error");

endmodule

// File: rtl/legacy_sysctl_ports.sv
module legacy_sysctl_ports
    import legacy_ports_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              portb_wr,
    input  logic              rtcidx_wr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] portb_rdata,
    input  logic              chk_err_n,
    input  logic              bus_err_n,
    input  logic              refresh_pulse,
    input  logic              tmr2_out,
    output logic              tmr2_gate,
    output logic              spkr,
    output logic              nmi_req,
    output logic [RTC_AW-1:0] rtc_index
);

    localparam int CTL_BASE = 2;

    logic [NUM_ERR_SRC-1:0] err_raw_n;
    logic [NUM_ERR_SRC-1:0] err_sync_n;
    logic [NUM_ERR_SRC-1:0] err_flag;
    logic [NUM_ERR_SRC-1:0] err_dis;

    logic              t2_en_q;
    logic              spk_en_q;
    logic              refr_tgl_q;
    logic              nmi_mask_q;
    logic [RTC_AW-1:0] rtc_idx_q;

    // index 0: system error (control bit 2), index 1: channel check (bit 3)
    assign err_raw_n = {chk_err_n, bus_err_n};

    for (genvar gi = 0; gi < NUM_ERR_SRC; gi++) begin : g_src
        lp_sync_chain #(
            .STAGES    (SYNC_STAGES),
            .RESET_VAL (1'b1)
        ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (err_raw_n[gi]),
            .q     (err_sync_n[gi])
        );

        lp_err_source u_src (
            .clk     (clk),
            .rst_n   (rst_n),
            .err_hit (!err_sync_n[gi]),
            .wr_ctl  (portb_wr),
            .wr_bit  (wr_data[CTL_BASE+gi]),
            .flag    (err_flag[gi]),
            .dis     (err_dis[gi])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t2_en_q  <= 1'b0;
            spk_en_q <= 1'b0;
        end else if (portb_wr) begin
            t2_en_q  <= wr_data[0];
            spk_en_q <= wr_data[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            refr_tgl_q <= 1'b0;
        end else if (refresh_pulse) begin
            refr_tgl_q <= !refr_tgl_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_mask_q <= 1'b1;
            rtc_idx_q  <= '0;
        end else if (rtcidx_wr) begin
            nmi_mask_q <= wr_data[BYTE_W-1];
            rtc_idx_q  <= wr_data[RTC_AW-1:0];
        end
    end

    always_comb begin
        portb_rdata = {err_flag[0], err_flag[1], tmr2_out, refr_tgl_q,
                       err_dis[1], err_dis[0], spk_en_q, t2_en_q};
        tmr2_gate   = t2_en_q;
        spkr        = spk_en_q && tmr2_out;
        nmi_req     = (|err_flag) && !nmi_mask_q;
        rtc_index   = rtc_idx_q;
    end

    assert_gate_follows_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        portb_wr |=> (tmr2_gate == $past(wr_data[0])))
        else $error("counter 2 gate did not take written value");

    assert_speaker_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr2_out |-> !spkr)
        else $error("speaker high while counter 2 output low");

    assert_refresh_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_pulse |=> (portb_rdata[4] != $past(portb_rdata[4])))
        else $error("refresh toggle did not flip");

    assert_refresh_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !refresh_pulse |=> $stable(portb_rdata[4]))
        else $error("refresh toggle changed without a refresh");

    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_mask_q |-> !nmi_req)
        else $error("NMI raised while masked");

    assert_mask_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rtcidx_wr |=> (nmi_mask_q == $past(wr_data[BYTE_W-1])))
        else $error("master mask not loaded from bit 7");

endmodule

// File: tb/legacy_sysctl_ports_tb_top.sv
module legacy_sysctl_ports_tb_top;

    logic       clk;
    logic       rst_n;
    logic       portb_wr;
    logic       rtcidx_wr;
    logic [7:0] wr_data;
    logic [7:0] portb_rdata;
    logic       chk_err_n;
    logic       bus_err_n;
    logic       refresh_pulse;
    logic       tmr2_out;
    logic       tmr2_gate;
    logic       spkr;
    logic       nmi_req;
    logic [6:0] rtc_index;

    int  vec_cnt  = 0;
    int  miss_cnt = 0;
    bit  done     = 1'b0;

    legacy_sysctl_ports dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .portb_wr      (portb_wr),
        .rtcidx_wr     (rtcidx_wr),
        .wr_data       (wr_data),
        .portb_rdata   (portb_rdata),
        .chk_err_n     (chk_err_n),
        .bus_err_n     (bus_err_n),
        .refresh_pulse (refresh_pulse),
        .tmr2_out      (tmr2_out),
        .tmr2_gate     (tmr2_gate),
        .spkr          (spkr),
        .nmi_req       (nmi_req),
        .rtc_index     (rtc_index)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // behavioural reference model; index 0 = system error, 1 = channel check
    bit       m_t2, m_spk, m_tgl, m_mask;
    bit [6:0] m_rtc;
    bit [1:0] m_flag, m_dis, m_s1, m_s2;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_t2 = 0; m_spk = 0; m_tgl = 0; m_mask = 1; m_rtc = 0;
            m_flag = 0; m_dis = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            for (int i = 0; i < 2; i++) begin
                if (portb_wr && wr_data[2+i]) begin
                    m_flag[i] = 1'b0;
                    m_dis[i]  = 1'b1;
                end else begin
                    if (!m_dis[i] && m_s2[i]) m_flag[i] = 1'b1;
                    if (portb_wr) m_dis[i] = 1'b0;
                end
            end
            m_s2 = m_s1;
            m_s1 = {~chk_err_n, ~bus_err_n};
            if (portb_wr) begin
                m_t2  = wr_data[0];
                m_spk = wr_data[1];
            end
            if (refresh_pulse) m_tgl = ~m_tgl;
            if (rtcidx_wr) begin
                m_mask = wr_data[7];
                m_rtc  = wr_data[6:0];
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        vec_cnt++;
        if (got !== exp) begin
            miss_cnt++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R5 flags", {6'd0, portb_rdata[7:6]}, {6'd0, m_flag[0], m_flag[1]});
            chk("R9 readback", {3'd0, portb_rdata[5], portb_rdata[3:0]},
                {3'd0, tmr2_out, m_dis[1], m_dis[0], m_spk, m_t2});
            chk("R4 toggle", {7'd0, portb_rdata[4]}, {7'd0, m_tgl});
            chk("R2 gate", {7'd0, tmr2_gate}, {7'd0, m_t2});
            chk("R3 speaker", {7'd0, spkr}, {7'd0, m_spk & tmr2_out});
            chk("R7 nmi", {7'd0, nmi_req}, {7'd0, (|m_flag) & ~m_mask});
            chk("R8 rtc index", {1'b0, rtc_index}, {1'b0, m_rtc});
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wr_b(input logic [7:0] d);
        portb_wr = 1'b1; wr_data = d;
        tick();
        portb_wr = 1'b0;
    endtask

    task automatic wr_70(input logic [7:0] d);
        rtcidx_wr = 1'b1; wr_data = d;
        tick();
        rtcidx_wr = 1'b0;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miss_cnt++;
            $display("FAIL R1 watchdog got running exp finished");
            done = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 0; portb_wr = 0; rtcidx_wr = 0; wr_data = 0;
        chk_err_n = 1; bus_err_n = 1; refresh_pulse = 0; tmr2_out = 0;
        tick(3);
        rst_n = 1;
        tick();
        // R1 reset values
        chk("R1 read byte", portb_rdata, 8'h00);
        chk("R1 outputs", {4'd0, tmr2_gate, spkr, nmi_req, 1'b0}, 8'h00);
        chk("R1 rtc index", {1'b0, rtc_index}, 8'h00);
        // R1 mask resets to 1: captured error gives no NMI
        bus_err_n = 0; tick(3);
        chk("R1 flag set while masked", {7'd0, portb_rdata[7]}, 8'h01);
        chk("R1 nmi masked at reset", {7'd0, nmi_req}, 8'h00);
        bus_err_n = 1; tick(3);
        wr_b(8'h04); wr_b(8'h00);

        // R2 and R3: gate and speaker
        wr_b(8'h03);
        chk("R2 gate on", {7'd0, tmr2_gate}, 8'h01);
        for (int k = 0; k < 6; k++) begin
            tmr2_out = k[0]; tick();
            chk("R3 speaker follows", {7'd0, spkr}, {7'd0, k[0]});
            chk("R9 live level", {7'd0, portb_rdata[5]}, {7'd0, k[0]});
        end
        wr_b(8'h01); tmr2_out = 1; tick();
        chk("R3 speaker gated off", {7'd0, spkr}, 8'h00);
        wr_b(8'h00); tmr2_out = 0;
        chk("R2 gate off", {7'd0, tmr2_gate}, 8'h00);

        // R4 refresh toggle
        for (int k = 0; k < 3; k++) begin
            refresh_pulse = 1; tick();
            refresh_pulse = 0; tick();
            chk("R4 toggles", {7'd0, portb_rdata[4]}, {7'd0, ~k[0]});
        end
        wr_b(8'h10);
        chk("R4 write ignored", {7'd0, portb_rdata[4]}, 8'h01);
        wr_b(8'h00);

        // R5 R6 R7 R8 with system error
        wr_70(8'h2A);
        chk("R8 rtc loaded", {1'b0, rtc_index}, 8'h2A);
        bus_err_n = 0; tick(2);
        chk("R5 not yet captured", {7'd0, portb_rdata[7]}, 8'h00);
        tick();
        chk("R5 captured", {7'd0, portb_rdata[7]}, 8'h01);
        chk("R7 nmi raised", {7'd0, nmi_req}, 8'h01);
        bus_err_n = 1; tick(4);
        chk("R5 sticky", {7'd0, portb_rdata[7]}, 8'h01);
        wr_b(8'h00);
        chk("R6 zero write keeps flag", {7'd0, portb_rdata[7]}, 8'h01);
        wr_70(8'h91);
        chk("R8 masked", {7'd0, nmi_req}, 8'h00);
        wr_70(8'h55);
        chk("R8 rtc no effect on nmi", {7'd0, nmi_req}, 8'h01);
        wr_b(8'h04);
        chk("R6 cleared", {portb_rdata[7], nmi_req, 6'd0}, 8'h00);
        bus_err_n = 0; tick(4);
        chk("R6 disabled no capture", {7'd0, portb_rdata[7]}, 8'h00);
        bus_err_n = 1; tick(3);
        wr_b(8'h00);

        // R5 channel check, bit 6
        chk_err_n = 0; tick(3);
        chk("R5 check flag", {7'd0, portb_rdata[6]}, 8'h01);
        chk_err_n = 1; tick(3);
        wr_b(8'h08);
        chk("R6 check cleared", {7'd0, portb_rdata[6]}, 8'h00);
        wr_b(8'h00);

        // R10 clear in capture cycle
        chk_err_n = 0; tick(2);
        wr_b(8'h08);
        chk("R10 clear wins", {6'd0, portb_rdata[6], portb_rdata[3]}, 8'h01);
        chk_err_n = 1; tick(3);
        wr_b(8'h00);

        // random mix, compared against model every cycle
        for (int k = 0; k < 600; k++) begin
            int r;
            r = int'($urandom_range(0, 99));
            portb_wr      = (r < 12);
            rtcidx_wr     = (r >= 12 && r < 18);
            wr_data       = 8'($urandom_range(0, 255));
            refresh_pulse = ($urandom_range(0, 3) == 0);
            tmr2_out      = $urandom_range(0, 1) != 0;
            if ($urandom_range(0, 9) == 0) bus_err_n = ~bus_err_n;
            if ($urandom_range(0, 9) == 0) chk_err_n = ~chk_err_n;
            tick();
        end
        portb_wr = 0; rtcidx_wr = 0; refresh_pulse = 0;
        tick(2);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule